// File: doc/BRIEF.md
# Pixel-to-Bus Transfer Serializer

This block sits between a pixel stream and a strobe timer that drives a narrow parallel display bus. It accepts pixels through a valid/ready handshake and cuts each one into as many bus words as the bus needs. The number of words depends on the selected pixel depth (12, 16, 18 or 24 bits) and the selected bus width (8, 9, 12 or 16 lines). Words leave most significant bits first. For every word the block raises a transfer request toward the strobe timer and holds the word until the timer acknowledges it.

The block chooses a cycle format from the two selectors. The ratio of depth to lines may be a whole number (one, two or three words per pixel). The ratio may instead be one and a half, in which case two pixels are packed back to back into three words. Any other pairing of depth and width is illegal. An illegal pairing raises an error flag and stops the block. The selected format is also driven out so that the strobe timer can see it. The selectors are expected to stay stable while pixels are in flight.

Top module: `pixel_bus_serializer`

## Requirements
- R1: `depthSel` codes 0,1,2,3 mean 12,16,18,24 bits per pixel. `widthSel` codes 0,1,2,3 mean 8,9,12,16 data lines. `cycleFmt` reads 0 for one word per pixel, 1 for two, 2 for three, and 3 for three words per two pixels.
- R2: The format is (depth/lines − 1) when depth is exactly 1, 2 or 3 times lines. Otherwise it is 3 when twice the depth equals three times lines. Every other pairing sets `cfgErr` high.
- R3: Each word carries the next `lines` bits of the pixel stream, most significant first, right-aligned in `busWord`. Bus bits at and above `lines` are zero.
- R4: On an 8-line bus, a 16-bit pixel goes out as bits 15:8 then 7:0. A 24-bit pixel goes out as 23:16, then 15:8, then 7:0.
- R5: A 16-bit pixel on a 16-line bus takes exactly one transfer. In every format, the number of words sent equals pixels × depth / lines.
- R6: In format 3, two pixels fill three words: the first pixel's bits come first and the second pixel's bits follow with no gap. No word is requested until the second pixel is accepted.
- R7: `pixReady` stays low from acceptance of the pixel that completes a group until the last word of that group is acknowledged.
- R8: Once raised, `xferReq` stays high and `busWord` stays unchanged until a cycle with `xferAck` high. A word completes on a clock edge where both are high.
- R9: While `cfgErr` is high, `pixReady` and `xferReq` are both low, whatever `pixValid` does.
- R10: Pixel input bits at and above the selected depth have no effect on any word.
- R11: After reset with a legal configuration, `pixReady` is high, `xferReq` is low and `busWord` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depthSel | input | 2 | Pixel depth code |
| widthSel | input | 2 | Bus width code |
| pixValid | input | 1 | Pixel present |
| pixReady | output | 1 | Pixel accepted when high with pixValid |
| pixData | input | PIX_W | Pixel, right-aligned |
| busWord | output | BUS_W | Word for the bus, right-aligned |
| xferReq | output | 1 | Transfer request to the strobe timer |
| xferAck | input | 1 | Strobe timer has taken the word |
| cycleFmt | output | 2 | Selected cycle format |
| cfgErr | output | 1 | Illegal depth/width pairing |

## Verification
The bench builds the block with its defaults: a 24-bit pixel port and a 16-line bus. These are the widest values, so every code of both selectors can be reached. This covers all sixteen selector pairings, including all four cycle formats and the seven illegal pairings. Legal pairings are also run with the acknowledge throttled, which shows that words hold steady and that the pixel input stays closed while a group drains.

// File: rtl/pixser_pkg.sv
package pixser_pkg;

  typedef enum logic [1:0] {
    FMT_ONE   = 2'd0,
    FMT_TWO   = 2'd1,
    FMT_THREE = 2'd2,
    FMT_PAIR  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic shiftOut;
  } dpCtl_t;

  function automatic logic [4:0] depthBits(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd16;
      2'd2:    return 5'd18;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [4:0] laneBits(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd8;
      2'd1:    return 5'd9;
      2'd2:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/pixser_cfgdec.sv
module pixser_cfgdec
  import pixser_pkg::*;
(
  input  logic [1:0] depthSel,
  input  logic [1:0] widthSel,
  output logic [4:0] bpp,
  output logic [4:0] lines,
  output fmt_e       fmt,
  output logic       err
);
  logic [6:0] b7, l7;

  always_comb begin
    bpp   = depthBits(depthSel);
    lines = laneBits(widthSel);
    b7    = {2'b00, bpp};
    l7    = {2'b00, lines};
    err   = 1'b0;
    fmt   = FMT_ONE;
    if (b7 == l7)                           fmt = FMT_ONE;
    else if (b7 == (l7 << 1))               fmt = FMT_TWO;
    else if (b7 == 7'(l7 * 7'd3))           fmt = FMT_THREE;
    else if ((b7 << 1) == 7'(l7 * 7'd3))    fmt = FMT_PAIR;
    else                                    err = 1'b1;
  end
endmodule

// File: rtl/pixser_ctrl.sv
module pixser_ctrl
  import pixser_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   err,
  input  fmt_e   fmt,
  input  logic   pixValid,
  output logic   pixReady,
  output logic   xferReq,
  input  logic   xferAck,
  output dpCtl_t dpCtl
);
  typedef enum logic {ST_GATHER, ST_EMIT} state_e;

  state_e     state;
  logic       half;
  logic [1:0] cnt;
  logic [1:0] lastCnt;
  logic       accept;
  logic       groupDone;

  always_comb begin
    case (fmt)
      FMT_ONE: lastCnt = 2'd0;
      FMT_TWO: lastCnt = 2'd1;
      default: lastCnt = 2'd2;
    endcase
    pixReady  = !err && (state == ST_GATHER);
    xferReq   = !err && (state == ST_EMIT);
    accept    = pixValid && pixReady;
    groupDone = accept && !((fmt == FMT_PAIR) && !half);
    dpCtl.loadFirst  = accept && !((fmt == FMT_PAIR) && half);
    dpCtl.loadSecond = accept && (fmt == FMT_PAIR) && half;
    dpCtl.shiftOut   = xferReq && xferAck && (cnt != lastCnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || err) begin
      state <= ST_GATHER;
      half  <= 1'b0;
      cnt   <= 2'd0;
    end else begin
      case (state)
        ST_GATHER: begin
          if (accept) begin
            if ((fmt == FMT_PAIR) && !half) begin
              half <= 1'b1;
            end else begin
              half  <= 1'b0;
              cnt   <= 2'd0;
              state <= ST_EMIT;
            end
          end
        end
        default: begin
          if (xferAck) begin
            if (cnt == lastCnt) state <= ST_GATHER;
            else                cnt   <= cnt + 2'd1;
          end
        end
      endcase
    end
  end

  // R8: a pending request is not withdrawn
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n || err)
    (xferReq && !xferAck) |=> xferReq);

  // R7: input closes once a group is complete
  a_r7_ready_closed: assert property (@(posedge clk) disable iff (!rst_n || err)
    groupDone |=> (!pixReady && xferReq));

  // R6: first pixel of a pair starts no transfer
  a_r6_pair_waits: assert property (@(posedge clk) disable iff (!rst_n || err)
    (accept && (fmt == FMT_PAIR) && !half) |=> (pixReady && !xferReq));

  // R5: word counter never passes the group length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n || err)
    xferReq |-> (cnt <= lastCnt));
endmodule

// File: rtl/pixser_dpath.sv
module pixser_dpath
  import pixser_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtl_t           dpCtl,
  input  logic [4:0]       bpp,
  input  logic [4:0]       lines,
  input  logic [PIX_W-1:0] pixData,
  output logic [BUS_W-1:0] busWord
);
  localparam int SH_W = 2 * PIX_W;

  logic [SH_W-1:0]  shreg;
  logic [SH_W-1:0]  ext;
  logic [SH_W-1:0]  depthMask;
  logic [7:0]       firstSh, secondSh;
  logic [BUS_W-1:0] topWord;
  logic [7:0]       alignSh;

  always_comb begin
    depthMask = (SH_W'(1) << bpp) - SH_W'(1);
    ext       = SH_W'(pixData) & depthMask;
    firstSh   = 8'(SH_W) - {3'b000, bpp};
    secondSh  = 8'(SH_W) - {2'b00, bpp, 1'b0};
    topWord   = shreg[SH_W-1 -: BUS_W];
    alignSh   = 8'(BUS_W) - {3'b000, lines};
    busWord   = topWord >> alignSh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (dpCtl.loadFirst) begin
      shreg <= ext << firstSh;
    end else if (dpCtl.loadSecond) begin
      shreg <= shreg | (ext << secondSh);
    end else if (dpCtl.shiftOut) begin
      shreg <= shreg << lines;
    end
  end
endmodule

// File: rtl/pixel_bus_serializer.sv
module pixel_bus_serializer
  import pixser_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       depthSel,
  input  logic [1:0]       widthSel,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic [PIX_W-1:0] pixData,
  output logic [BUS_W-1:0] busWord,
  output logic             xferReq,
  input  logic             xferAck,
  output logic [1:0]       cycleFmt,
  output logic             cfgErr
);
  logic [4:0] bpp, lines;
  fmt_e       fmt;
  dpCtl_t     dpCtl;

  pixser_cfgdec u_dec (
    .depthSel (depthSel),
    .widthSel (widthSel),
    .bpp      (bpp),
    .lines    (lines),
    .fmt      (fmt),
    .err      (cfgErr)
  );

  pixser_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .err      (cfgErr),
    .fmt      (fmt),
    .pixValid (pixValid),
    .pixReady (pixReady),
    .xferReq  (xferReq),
    .xferAck  (xferAck),
    .dpCtl    (dpCtl)
  );

  pixser_dpath #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .dpCtl   (dpCtl),
    .bpp     (bpp),
    .lines   (lines),
    .pixData (pixData),
    .busWord (busWord)
  );

  assign cycleFmt = fmt;

  // R9: an illegal pairing blocks both sides
  a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |-> (!pixReady && !xferReq));

  // R8: the word under a pending request does not move
  a_r8_word_stable: assert property (@(posedge clk) disable iff (!rst_n || cfgErr)
    (xferReq && !xferAck) |=> $stable(busWord));

  // R3: lines beyond the selected width carry zero while requesting
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n || cfgErr)
    xferReq |-> ((busWord >> lines) == '0));
endmodule

// File: tb/tb_pixel_bus_serializer.sv
module tb_pixel_bus_serializer;
  localparam int PIX_W = 24;
  localparam int BUS_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       depthSel = 2'd1;
  logic [1:0]       widthSel = 2'd0;
  logic             pixValid = 1'b0;
  logic             pixReady;
  logic [PIX_W-1:0] pixData = '0;
  logic [BUS_W-1:0] busWord;
  logic             xferReq;
  logic             xferAck = 1'b0;
  logic [1:0]       cycleFmt;
  logic             cfgErr;

  int checks = 0;
  int fails  = 0;
  bit stallMode = 1'b0;
  int ackCnt = 0;
  logic [BUS_W-1:0] recv[$];
  bit               prevStalled = 1'b0;
  logic [BUS_W-1:0] prevWord = '0;

  always #4 clk = ~clk;

  pixel_bus_serializer #(.PIX_W(PIX_W), .BUS_W(BUS_W)) dut (
    .clk(clk), .rst_n(rst_n), .depthSel(depthSel), .widthSel(widthSel),
    .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData),
    .busWord(busWord), .xferReq(xferReq), .xferAck(xferAck),
    .cycleFmt(cycleFmt), .cfgErr(cfgErr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int depthOf(input int c);
    case (c) 0: return 12; 1: return 16; 2: return 18; default: return 24; endcase
  endfunction

  function automatic int linesOf(input int c);
    case (c) 0: return 8; 1: return 9; 2: return 12; default: return 16; endcase
  endfunction

  // expected format, -1 for illegal
  function automatic int expFmt(input int b, input int l);
    if ((b % l) == 0 && (b / l) >= 1 && (b / l) <= 3) return (b / l) - 1;
    if (((2 * b) % l) == 0 && ((2 * b) / l) == 3) return 3;
    return -1;
  endfunction

  // acknowledge driver
  always @(negedge clk) begin
    ackCnt <= ackCnt + 1;
    xferAck <= stallMode ? ((ackCnt % 4) == 3) : 1'b1;
  end

  // monitor: words, hold behaviour, closed input
  always @(negedge clk) begin
    #1;
    if (rst_n && !cfgErr) begin
      if (prevStalled) begin
        check(xferReq == 1'b1, "R8 request held", xferReq, 1);
        check(busWord == prevWord, "R8 word stable", busWord, prevWord);
      end
      if (xferReq) check(pixReady == 1'b0, "R7 ready low while sending", pixReady, 0);
      if (xferReq && xferAck) recv.push_back(busWord);
      prevStalled = xferReq && !xferAck;
      prevWord    = busWord;
    end else begin
      prevStalled = 1'b0;
    end
  end

  task automatic pushPix(input logic [PIX_W-1:0] d);
    @(negedge clk);
    pixValid = 1'b1;
    pixData  = d;
    #1;
    while (!pixReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  // R3 R4 R5 R6 R10: stream a run of pixels and compare every word
  task automatic runCase(input int dc, input int wc, input int npix, input bit stall,
                         input int seed, input string tag);
    int b, l, nWords;
    bit bits[$];
    logic [BUS_W-1:0] w;
    logic [PIX_W-1:0] d;
    @(negedge clk);
    depthSel  = 2'(dc);
    widthSel  = 2'(wc);
    stallMode = stall;
    recv.delete();
    b = depthOf(dc);
    l = linesOf(wc);
    for (int i = 0; i < npix; i++) begin
      d = PIX_W'(32'h9E3779B9 * (i + 1 + seed));
      for (int k = b - 1; k >= 0; k--) bits.push_back(d[k]);
      pushPix(d);
    end
    nWords = (npix * b) / l;
    for (int t = 0; t < 400 && recv.size() < nWords; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(recv.size() == nWords, {tag, " word count"}, recv.size(), nWords);
    for (int j = 0; j < nWords && j < recv.size(); j++) begin
      w = '0;
      for (int k = 0; k < l; k++) w = {w[BUS_W-2:0], bits[j * l + k]};
      check(recv[j] == w, tag, recv[j], w);
    end
    stallMode = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    check(pixReady == 1'b1, "R11 reset ready", pixReady, 1);
    check(xferReq == 1'b0, "R11 reset no request", xferReq, 0);
    check(busWord == '0, "R11 reset word", busWord, 0);
  endtask

  task automatic testFormats();
    int e;
    for (int dc = 0; dc < 4; dc++) begin
      for (int wc = 0; wc < 4; wc++) begin
        @(negedge clk);
        depthSel = 2'(dc);
        widthSel = 2'(wc);
        #1;
        e = expFmt(depthOf(dc), linesOf(wc));
        check(cfgErr == (e < 0), "R2 error flag", cfgErr, (e < 0));
        if (e >= 0) check(cycleFmt == 2'(e), "R1 format code", cycleFmt, e);
      end
    end
  endtask

  task automatic testError();
    @(negedge clk);
    depthSel = 2'd1;
    widthSel = 2'd1;
    pixValid = 1'b1;
    pixData  = 24'h123456;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #1;
      check(cfgErr == 1'b1, "R9 error raised", cfgErr, 1);
      check(pixReady == 1'b0, "R9 ready blocked", pixReady, 0);
      check(xferReq == 1'b0, "R9 request blocked", xferReq, 0);
    end
    pixValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic testPairWaits();
    // R6: one pixel of a pair sends nothing; the second releases three words
    @(negedge clk);
    depthSel = 2'd0;
    widthSel = 2'd0;
    recv.delete();
    pushPix(24'hFFFABC);
    repeat (5) @(negedge clk);
    check(recv.size() == 0, "R6 no word after first pixel", recv.size(), 0);
    pushPix(24'h000DEF);
    repeat (8) @(negedge clk);
    check(recv.size() == 3, "R6 three words per pair", recv.size(), 3);
    if (recv.size() == 3) begin
      check(recv[0] == 16'h00AB, "R6 word0", recv[0], 16'h00AB);
      check(recv[1] == 16'h00CD, "R6 word1", recv[1], 16'h00CD);
      check(recv[2] == 16'h00EF, "R6 word2", recv[2], 16'h00EF);
    end
  endtask

  task automatic testByteOrder();
    // R4: explicit byte order on the 8-line bus
    @(negedge clk);
    depthSel = 2'd1;
    widthSel = 2'd0;
    recv.delete();
    pushPix(24'hEE1234);
    repeat (6) @(negedge clk);
    check(recv.size() == 2, "R4 16-bit on 8 lines count", recv.size(), 2);
    if (recv.size() == 2) begin
      check(recv[0] == 16'h0012, "R4 high byte first", recv[0], 16'h0012);
      check(recv[1] == 16'h0034, "R4 low byte second", recv[1], 16'h0034);
    end
    @(negedge clk);
    depthSel = 2'd3;
    recv.delete();
    pushPix(24'hA1B2C3);
    repeat (8) @(negedge clk);
    check(recv.size() == 3, "R4 24-bit on 8 lines count", recv.size(), 3);
    if (recv.size() == 3) begin
      check(recv[0] == 16'h00A1, "R4 bits 23:16", recv[0], 16'h00A1);
      check(recv[1] == 16'h00B2, "R4 bits 15:8", recv[1], 16'h00B2);
      check(recv[2] == 16'h00C3, "R4 bits 7:0", recv[2], 16'h00C3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testFormats();
    testByteOrder();
    runCase(1, 3, 5, 1'b0, 1, "R5 16-bit on 16 lines");
    runCase(1, 3, 4, 1'b1, 2, "R5 16-bit on 16 lines stalled");
    runCase(0, 2, 4, 1'b0, 3, "R5 12-bit on 12 lines");
    runCase(2, 1, 4, 1'b1, 4, "R3 18-bit on 9 lines");
    runCase(3, 2, 4, 1'b0, 5, "R3 24-bit on 12 lines");
    runCase(3, 0, 3, 1'b1, 6, "R10 24-bit on 8 lines");
    runCase(0, 0, 6, 1'b1, 7, "R6 12-bit on 8 lines pairs");
    runCase(2, 2, 4, 1'b0, 8, "R6 18-bit on 12 lines pairs");
    runCase(3, 3, 4, 1'b1, 9, "R6 24-bit on 16 lines pairs");
    runCase(1, 0, 4, 1'b0, 10, "R10 16-bit on 8 lines upper bits");
    testPairWaits();
    testError();
    runCase(1, 0, 2, 1'b0, 11, "R9 recovery after error");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule